// File: doc/BRIEF.md
# Stepped Stereo Attenuation Sequencer

This block keeps an applied attenuation code for each of two audio channels and moves that code toward a programmed goal. One attenuation step is 0.5 dB. The rest of the chip writes a target code per channel, raises mute requests, and picks one of two update modes. In ramp mode the applied code moves by one step at a time, paced by the audio frame strobe at one of four selectable rates. In crossing mode the applied code jumps straight to the goal when that channel's signal passes through zero. If the signal never crosses zero, a timeout forces the jump.

The block also watches the signed sample stream of each channel. When auto-mute is enabled, a long run of static samples (every bit clear, or every bit set) turns the channel's goal into the mute code. A mute request does the same. In both cases the move toward mute uses the current mode, and the move back to the target when the mute ends also uses the current mode.

A per-channel acknowledge bit shows that a written target has not yet been reached. The gain multiplier that uses the code is outside this block.

Top module: `vol_step_ctrl`

## Requirements
- R1: Codes 0 to 227 are applied levels. A target above 227 is treated as the mute code 228. The applied code output never exceeds 228, and a channel's muted flag is high exactly when its applied code is 228.
- R2: In ramp mode (zc_mode = 0) the applied code moves by exactly one toward the goal on a paced frame strobe. The period P is set by ramp_rate: 2'b00 gives 8 frames, 2'b01 gives 4, 2'b10 gives 16 and 2'b11 gives 32. The paced strobes are those whose 1-based count since reset is a multiple of P.
- R3: The applied code changes only on the clock edge that captures a frame strobe.
- R4: In crossing mode (zc_mode = 1) the applied code jumps to the goal in one move on a frame strobe where the channel's sample is exactly zero, or where its sign bit differs from the sign bit of the previous strobe's sample. Before the first sample, the previous sample is taken as positive.
- R5: In crossing mode, if no crossing occurs, the jump is forced on the 512th frame strobe after the goal last became pending. Every target write restarts this count.
- R6: The two channels are independent: the stimulus of one channel never moves the other channel's code.
- R7: A channel's acknowledge bit is high in the cycle after a target write. It stays high until the applied code equals the goal, and then it returns low.
- R8: With auto_mute_en = 1, a channel's goal becomes 228 after 512 consecutive static samples, where a static sample has every bit 0 or every bit 1. One sample of any other value releases the mute and restores the target as the goal.
- R9: A mute request makes the goal 228 under the current mode. Releasing the request returns the goal to the target code.
- R10: After reset the applied codes are 0, and the acknowledge and muted flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe per audio frame; the samples are valid with it |
| samp_l | input | 24 | Left signed sample |
| samp_r | input | 24 | Right signed sample |
| zc_mode | input | 1 | 0 = ramp mode, 1 = crossing mode |
| ramp_rate | input | 2 | Ramp pacing select |
| auto_mute_en | input | 1 | Enables the static-run mute |
| tgt_wr_l | input | 1 | Left target write strobe |
| tgt_l | input | 8 | Left target code |
| tgt_wr_r | input | 1 | Right target write strobe |
| tgt_r | input | 8 | Right target code |
| mute_req_l | input | 1 | Left mute request |
| mute_req_r | input | 1 | Right mute request |
| att_l | output | 8 | Left applied code |
| att_r | output | 8 | Right applied code |
| muted_l | output | 1 | Left channel at the mute code |
| muted_r | output | 1 | Right channel at the mute code |
| ack_l | output | 1 | Left target change pending |
| ack_r | output | 1 | Right target change pending |

## Verification
On every cycle the assertions check four properties:
- the applied codes stay within range;
- a code changes only after a frame strobe;
- a code moves by at most one step while in ramp mode;
- a target write always raises the acknowledge bit.

The pacing phase of each of the four ramp rates, the exact frame on which a crossing or a 512-frame timeout applies the level, and the restart of that timeout by a rewrite are shown only by the bench scenarios. The same holds for the 512-sample auto-mute run and its one-sample release.

// File: rtl/vol_pkg.sv
package vol_pkg;

  typedef enum logic {
    MODE_RAMP = 1'b0,
    MODE_XING = 1'b1
  } vol_mode_e;

  // log2 of the number of frames per ramp step, per rate select
  function automatic logic [2:0] rate_shift(input logic [1:0] sel);
    logic [2:0] s;
    case (sel)
      2'b00:   s = 3'd3;
      2'b01:   s = 3'd2;
      2'b10:   s = 3'd4;
      default: s = 3'd5;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vol_frame_pacer.sv
module vol_frame_pacer #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic [1:0] ramp_rate,
  output logic       step_en
);
  import vol_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask    = CNT_W'((32'd1 << rate_shift(ramp_rate)) - 32'd1);
    step_en = frame_tick && ((cnt_q & mask) == mask);
    cnt_d   = cnt_q;
    if (frame_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/vol_sig_watch.sv
module vol_sig_watch #(
  parameter int SAMP_W  = 24,
  parameter int RUN_LEN = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_tick,
  input  logic signed [SAMP_W-1:0] sample,
  output logic                     zc_hit,
  output logic                     static_full
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);

  logic             prev_neg_q, prev_neg_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             is_zero, is_static;

  always_comb begin
    is_zero     = (sample == '0);
    is_static   = is_zero || (sample == '1);
    zc_hit      = frame_tick && (is_zero || (sample[SAMP_W-1] != prev_neg_q));
    static_full = (run_q == RUN_TOP);
    prev_neg_d  = prev_neg_q;
    run_d       = run_q;
    if (frame_tick) begin
      prev_neg_d = sample[SAMP_W-1];
      if (!is_static)          run_d = '0;
      else if (run_q != RUN_TOP) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg_q <= 1'b0;
      run_q      <= '0;
    end else begin
      prev_neg_q <= prev_neg_d;
      run_q      <= run_d;
    end
  end

endmodule

// File: rtl/vol_chan_seq.sv
module vol_chan_seq #(
  parameter int CODE_W  = 8,
  parameter int MAX_LVL = 227,
  parameter int TO_LEN  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              step_en,
  input  logic              zc_mode,
  input  logic              zc_hit,
  input  logic              force_mute,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_code,
  output logic [CODE_W-1:0] att,
  output logic              muted,
  output logic              ack
);
  import vol_pkg::*;

  localparam int TO_W = $clog2(TO_LEN);
  localparam logic [TO_W-1:0]   TO_LAST  = TO_W'(TO_LEN - 1);
  localparam logic [CODE_W-1:0] TOP_LVL  = CODE_W'(MAX_LVL);
  localparam logic [CODE_W-1:0] MUTE_LVL = CODE_W'(MAX_LVL + 1);

  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic [CODE_W-1:0] att_q, att_d;
  logic [TO_W-1:0]   to_q, to_d;
  logic              ack_q, ack_d;
  logic [CODE_W-1:0] goal;
  logic              pending;
  vol_mode_e         mode;

  always_comb begin
    mode    = vol_mode_e'(zc_mode);
    goal    = (force_mute || (tgt_q > TOP_LVL)) ? MUTE_LVL : tgt_q;
    pending = (att_q != goal);

    tgt_d = tgt_wr ? tgt_code : tgt_q;

    att_d = att_q;
    if (mode == MODE_RAMP) begin
      if (step_en && pending)
        att_d = (att_q > goal) ? att_q - 1'b1 : att_q + 1'b1;
    end else begin
      if (frame_tick && pending && (zc_hit || (to_q == TO_LAST)))
        att_d = goal;
    end

    to_d = to_q;
    if (tgt_wr || !pending)             to_d = '0;
    else if (frame_tick && mode == MODE_XING)
      to_d = (to_q == TO_LAST) ? '0 : to_q + 1'b1;

    ack_d = ack_q;
    if (tgt_wr)        ack_d = 1'b1;
    else if (!pending) ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      att_q <= '0;
      to_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      att_q <= att_d;
      to_q  <= to_d;
      ack_q <= ack_d;
    end
  end

  assign att   = att_q;
  assign muted = (att_q > TOP_LVL);
  assign ack   = ack_q;

endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl #(
  parameter int CODE_W     = 8,
  parameter int SAMP_W     = 24,
  parameter int MAX_LVL    = 227,
  parameter int RUN_LEN    = 512,
  parameter int ZC_TIMEOUT = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_tick,
  input  logic signed [SAMP_W-1:0] samp_l,
  input  logic signed [SAMP_W-1:0] samp_r,
  input  logic                     zc_mode,
  input  logic [1:0]               ramp_rate,
  input  logic                     auto_mute_en,
  input  logic                     tgt_wr_l,
  input  logic [CODE_W-1:0]        tgt_l,
  input  logic                     tgt_wr_r,
  input  logic [CODE_W-1:0]        tgt_r,
  input  logic                     mute_req_l,
  input  logic                     mute_req_r,
  output logic [CODE_W-1:0]        att_l,
  output logic [CODE_W-1:0]        att_r,
  output logic                     muted_l,
  output logic                     muted_r,
  output logic                     ack_l,
  output logic                     ack_r
);
  localparam int NCH    = 2;
  localparam int PACE_W = 5;  // longest pacing period is 32 frames

  logic                     step_en;
  logic signed [SAMP_W-1:0] samp_a  [NCH];
  logic                     wr_a    [NCH];
  logic [CODE_W-1:0]        tgt_a   [NCH];
  logic                     mreq_a  [NCH];
  logic [CODE_W-1:0]        att_a   [NCH];
  logic                     muted_a [NCH];
  logic                     ack_a   [NCH];

  assign samp_a[0] = samp_l;      assign samp_a[1] = samp_r;
  assign wr_a[0]   = tgt_wr_l;    assign wr_a[1]   = tgt_wr_r;
  assign tgt_a[0]  = tgt_l;       assign tgt_a[1]  = tgt_r;
  assign mreq_a[0] = mute_req_l;  assign mreq_a[1] = mute_req_r;

  vol_frame_pacer #(.CNT_W(PACE_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .ramp_rate(ramp_rate), .step_en(step_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic zc_hit, static_full, force_mute;

    vol_sig_watch #(.SAMP_W(SAMP_W), .RUN_LEN(RUN_LEN)) u_watch (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .sample(samp_a[c]), .zc_hit(zc_hit), .static_full(static_full)
    );

    assign force_mute = mreq_a[c] || (auto_mute_en && static_full);

    vol_chan_seq #(.CODE_W(CODE_W), .MAX_LVL(MAX_LVL), .TO_LEN(ZC_TIMEOUT)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .step_en(step_en),
      .zc_mode(zc_mode), .zc_hit(zc_hit), .force_mute(force_mute),
      .tgt_wr(wr_a[c]), .tgt_code(tgt_a[c]),
      .att(att_a[c]), .muted(muted_a[c]), .ack(ack_a[c])
    );
  end

  assign att_l   = att_a[0];    assign att_r   = att_a[1];
  assign muted_l = muted_a[0];  assign muted_r = muted_a[1];
  assign ack_l   = ack_a[0];    assign ack_r   = ack_a[1];

endmodule

// File: rtl/vol_step_ctrl_chk.sv
module vol_step_ctrl_chk #(
  parameter int CODE_W  = 8,
  parameter int MAX_LVL = 227
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              zc_mode,
  input logic              tgt_wr_l,
  input logic              tgt_wr_r,
  input logic [CODE_W-1:0] att_l,
  input logic [CODE_W-1:0] att_r,
  input logic              ack_l,
  input logic              ack_r
);
  localparam logic [CODE_W:0] MUTE_W = (CODE_W+1)'(MAX_LVL + 1);

  AST_ATT_RANGE_L: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, att_l} <= MUTE_W); // R1
  AST_ATT_RANGE_R: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, att_r} <= MUTE_W); // R1

  AST_FRAME_PACED_L: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(att_l)); // R3
  AST_FRAME_PACED_R: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(att_r)); // R3

  AST_ONE_STEP_L: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(zc_mode) |-> ($stable(att_l) ||
      ({1'b0, att_l} == {1'b0, $past(att_l)} + 1'b1) ||
      ({1'b0, att_l} + 1'b1 == {1'b0, $past(att_l)}))); // R2
  AST_ONE_STEP_R: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(zc_mode) |-> ($stable(att_r) ||
      ({1'b0, att_r} == {1'b0, $past(att_r)} + 1'b1) ||
      ({1'b0, att_r} + 1'b1 == {1'b0, $past(att_r)}))); // R2

  AST_ACK_RAISE_L: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tgt_wr_l) |-> ack_l); // R7
  AST_ACK_RAISE_R: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tgt_wr_r) |-> ack_r); // R7

endmodule

bind vol_step_ctrl vol_step_ctrl_chk #(.CODE_W(CODE_W), .MAX_LVL(MAX_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .zc_mode(zc_mode),
  .tgt_wr_l(tgt_wr_l), .tgt_wr_r(tgt_wr_r), .att_l(att_l), .att_r(att_r),
  .ack_l(ack_l), .ack_r(ack_r)
);

// File: tb/sim_vol_step_ctrl.sv
module sim_vol_step_ctrl;
  localparam int CW = 8;
  localparam int SW = 24;

  logic clk, rst_n, frame_tick, zc_mode, auto_mute_en;
  logic tgt_wr_l, tgt_wr_r, mute_req_l, mute_req_r;
  logic signed [SW-1:0] samp_l, samp_r;
  logic [1:0] ramp_rate;
  logic [CW-1:0] tgt_l, tgt_r, att_l, att_r;
  logic muted_l, muted_r, ack_l, ack_r;

  int total = 0;
  int bad   = 0;
  int fno   = 0;
  bit done  = 0;

  int    q_fno[$];
  int    q_ch[$];
  int    q_val[$];
  string q_req[$];

  vol_step_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .samp_l(samp_l), .samp_r(samp_r),
    .zc_mode(zc_mode), .ramp_rate(ramp_rate), .auto_mute_en(auto_mute_en),
    .tgt_wr_l(tgt_wr_l), .tgt_l(tgt_l), .tgt_wr_r(tgt_wr_r), .tgt_r(tgt_r),
    .mute_req_l(mute_req_l), .mute_req_r(mute_req_r),
    .att_l(att_l), .att_r(att_r), .muted_l(muted_l), .muted_r(muted_r),
    .ack_l(ack_l), .ack_r(ack_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s frame=%0d actual=%0d expected=%0d", req, fno, act, exp);
    end
  endtask

  task automatic push(input int f, input int c, input int v, input string r);
    q_fno.push_back(f); q_ch.push_back(c); q_val.push_back(v); q_req.push_back(r);
  endtask

  // expected ramp trajectory for both channels, frame by frame
  task automatic exp_ramp(input int al, input int gl, input int ar, input int gr,
                          input int p, input int from, input int upto);
    int a[2];
    int g[2];
    a[0] = al; a[1] = ar; g[0] = gl; g[1] = gr;
    for (int n = from + 1; n <= upto; n++) begin
      for (int c = 0; c < 2; c++) begin
        if ((n % p) == 0 && a[c] != g[c]) a[c] += (a[c] < g[c]) ? 1 : -1;
        push(n, c, a[c], "R2 R6");
      end
    end
  endtask

  task automatic frame(input int sl, input int sr);
    @(negedge clk);
    frame_tick = 1'b1; samp_l = SW'(sl); samp_r = SW'(sr);
    @(negedge clk);
    frame_tick = 1'b0;
    fno++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frames(input int n, input int sl, input int sr);
    repeat (n) frame(sl, sr);
  endtask

  task automatic wr(input int c, input int code);
    @(negedge clk);
    if (c == 0) begin tgt_wr_l = 1'b1; tgt_l = CW'(code); end
    else        begin tgt_wr_r = 1'b1; tgt_r = CW'(code); end
    @(negedge clk);
    tgt_wr_l = 1'b0; tgt_wr_r = 1'b0;
  endtask

  // monitor: compares applied codes against the scoreboard queue
  always @(negedge clk) begin
    #1;
    while (q_fno.size() > 0 && q_fno[0] <= fno) begin
      int c, v, f;
      string r;
      f = q_fno.pop_front(); c = q_ch.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
      chk(r, (c != 0) ? int'(att_r) : int'(att_l), v);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog frame=%0d actual=hung expected=done", fno);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; zc_mode = 1'b0; auto_mute_en = 1'b0;
    tgt_wr_l = 1'b0; tgt_wr_r = 1'b0; tgt_l = '0; tgt_r = '0;
    mute_req_l = 1'b0; mute_req_r = 1'b0; ramp_rate = 2'b01;
    samp_l = '0; samp_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 att_l", int'(att_l), 0);
    chk("R10 att_r", int'(att_r), 0);
    chk("R10 ack", int'({ack_l, ack_r}), 0);
    chk("R10 muted", int'({muted_l, muted_r}), 0);

    // ramp rate 01: one step per 4 frames
    wr(0, 3);
    chk("R7 ack_l after write", int'(ack_l), 1);
    exp_ramp(0, 3, 0, 0, 4, 0, 16);
    frames(16, 1000, 1000);
    chk("R7 ack_l cleared", int'(ack_l), 0);

    // rate 11: one step per 32 frames, downward
    ramp_rate = 2'b11;
    wr(0, 1);
    exp_ramp(3, 1, 0, 0, 32, 16, 64);
    frames(48, 1000, 1000);

    // rate 00: 8 frames, right channel only
    ramp_rate = 2'b00;
    wr(1, 2);
    exp_ramp(1, 1, 0, 2, 8, 64, 80);
    frames(16, 1000, 1000);

    // rate 10: 16 frames
    ramp_rate = 2'b10;
    wr(0, 3);
    exp_ramp(1, 3, 2, 2, 16, 80, 112);
    frames(32, 1000, 1000);

    // crossing mode, right target above 227 -> mute code
    zc_mode = 1'b1;
    wr(1, 250);
    chk("R7 ack_r after write", int'(ack_r), 1);
    for (int n = 113; n <= 115; n++) begin push(n, 0, 3, "R6"); push(n, 1, 2, "R4"); end
    push(116, 0, 3, "R6"); push(116, 1, 228, "R4 R1");
    frames(3, 500, 500);
    frame(500, -500);
    chk("R1 muted_r", int'(muted_r), 1);
    chk("R1 muted_l", int'(muted_l), 0);

    // forced update after 512 frames without a crossing
    wr(0, 10);
    push(627, 0, 3, "R5 early");
    push(628, 0, 10, "R5 forced");
    frames(512, 500, -500);
    chk("R7 ack_l after forced", int'(ack_l), 0);

    // each write restarts the timeout
    wr(0, 12);
    push(900, 0, 10, "R5 waiting");
    frames(300, 500, -500);
    chk("R7 ack_l pending", int'(ack_l), 1);
    wr(0, 14);
    push(1140, 0, 10, "R5 restart");
    push(1439, 0, 10, "R5 restart");
    push(1440, 0, 14, "R5 restart");
    frames(512, 500, -500);
    @(negedge clk);
    chk("R7 ack_l after restart", int'(ack_l), 0);

    // exact zero sample counts as a crossing
    wr(0, 5);
    push(1443, 0, 14, "R4 zero");
    push(1444, 0, 5, "R4 zero");
    frames(3, 500, -500);
    frame(0, -500);

    // explicit mute request under crossing mode
    @(negedge clk); mute_req_l = 1'b1;
    push(1447, 0, 5, "R9 mute");
    push(1448, 0, 228, "R9 mute");
    frames(3, 500, -500);
    frame(-500, -500);
    chk("R9 muted_l", int'(muted_l), 1);
    @(negedge clk); mute_req_l = 1'b0;
    push(1449, 0, 228, "R9 release");
    push(1450, 0, 5, "R9 release");
    frame(-500, -500);
    frame(500, -500);

    // auto-mute after 512 static samples, released by one other sample
    auto_mute_en = 1'b1;
    push(1962, 0, 5, "R8 run");
    push(1963, 0, 228, "R8 mute");
    push(1964, 0, 228, "R8 hold");
    push(1965, 0, 5, "R8 release");
    push(1965, 1, 228, "R6");
    frames(512, 0, -500);
    frame(0, -500);
    chk("R8 muted_l", int'(muted_l), 1);
    frame(700, -500);
    frame(-700, -500);
    chk("R8 muted_l released", int'(muted_l), 0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule